// File: doc/BRIEF.md
# Linear Sensor Pixel-Select Sequencer

This block is the digital readout sequencer of one section of a linear image sensor. A single-cycle start token on the serial input is clocked into a shift chain of one-hot select stages, one stage per pixel. Each stage gates one pixel onto a shared output word, so the section's pixels appear in order, one per clock. The pixel values are digital words on a wide input bus. They are frozen into a capture bank on the rising edge of a separate hold input. In normal use that input is tied to the serial input. The same token also opens a fixed integrator-reset window.

When the token reaches the last stage it is driven out on the serial output. One clock later both the serial output and the output-enable flag drop. Wiring one section's serial output to the next section's serial input therefore yields one unbroken stream twice as long. Two flags report misuse. One marks a start pulse held high for more than one clock. The other marks a fresh token that arrives while a readout is still in progress. Such a token restarts the scan from the first pixel.

Top module: `linescan_seq`

## Requirements
- R1: A token is accepted at a rising clock edge where `serIn` is 1 and was 0 at the previous edge (0 after reset). After that edge `pixValid` and `outEn` are 1, `pixIndex` is 0 and `pixSel` bit 0 is set.
- R2: While a readout runs and no new token arrives, each edge moves the selection to the next pixel. `pixIndex` equals k and `pixSel` has only bit k set. `pixSel` is all zero and `pixIndex` is 0 when no readout runs.
- R3: While `pixValid` is 1, `pixData` equals the captured word of pixel `pixIndex`, where pixel k is taken from `pixIn[k*DATA_W +: DATA_W]`. `pixData` is 0 while `pixValid` is 0.
- R4: Counting the accepting edge as edge 1, `serOut` is 1 only after edge NUM_PIX (384), together with the last pixel. Edge NUM_PIX+1 clears `serOut`, `outEn` and `pixValid`, unless that edge accepts a new token.
- R5: An edge where `holdIn` is 1 and was 0 at the previous edge loads every pixel's word from `pixIn` at once. Changes on `pixIn` at any other time do not alter `pixData`.
- R6: `intReset` is 1 for exactly RESET_WIN (18) cycles after an edge that accepts a token or sees a hold rise. Each such edge reloads the full window.
- R7: If `serIn` is 1 at two consecutive edges, `protoErr` is 1 for the cycle after the second edge, and that second edge starts no new readout.
- R8: A token accepted while `pixValid` is 1 and `serOut` is 0 restarts the readout at pixel 0 and raises `overrun` for one cycle. A token accepted on the edge that retires the last pixel starts a new readout without `overrun`.
- R9: With `serOut` of one section driving `serIn` of a second, and both holds tied together, the second section presents its pixels 0 to 383 on edges 385 to 768. Its `serOut` is 1 after edge 768 and is cleared by edge 769.
- R10: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Section clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| serIn | input | 1 | Start token input |
| holdIn | input | 1 | Capture strobe; rising edge freezes all pixel words |
| pixIn | input | NUM_PIX*DATA_W | All pixel words, pixel k at bits k*DATA_W upward |
| pixSel | output | NUM_PIX | One-hot pixel select lines |
| pixData | output | DATA_W | Captured word of the selected pixel |
| pixValid | output | 1 | Qualifies pixData and pixIndex |
| pixIndex | output | $clog2(NUM_PIX) | Position of the selected pixel |
| serOut | output | 1 | Token leaving the last stage, for cascading |
| outEn | output | 1 | Output driven; low stands for high impedance |
| intReset | output | 1 | Integrator-reset window |
| protoErr | output | 1 | Start pulse held longer than one clock |
| overrun | output | 1 | Readout restarted by an early token |

## Verification
Every output is a register, or a plain decode of registers, updated by the edge that samples the stimulus. The selection, data, flags and reset window are therefore due one edge after the inputs that cause them. The serial output is due NUM_PIX edges after the token edge, and the cascaded section's outputs trail by a further NUM_PIX edges. The bench drives inputs 1 ns after a rising edge and advances a cycle model of the requirements at each edge. It compares every output of both sections 1 ns after that edge, so each expected value is sampled in the cycle it is due, including the last-pixel edge, the retiring edge and the 18th cycle of the window.

// File: rtl/linescan_pkg.sv
`timescale 1ns/1ps
package linescan_pkg;

  // Strobes passed from the sequencing control to the datapath.
  typedef struct packed {
    logic capture;  // load every pixel word this edge
    logic valid;    // a pixel is currently selected
  } seqStrobe_t;

endpackage

// File: rtl/linescan_ctrl.sv
`timescale 1ns/1ps
module linescan_ctrl
  import linescan_pkg::*;
#(
  parameter int NUM_PIX   = 384,
  parameter int RESET_WIN = 18,
  parameter int IDX_W     = $clog2(NUM_PIX),
  parameter int WIN_W     = $clog2(RESET_WIN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serIn,
  input  logic               holdIn,
  output seqStrobe_t         strobe,
  output logic [IDX_W-1:0]   pixIndex,
  output logic [NUM_PIX-1:0] pixSel,
  output logic               serOut,
  output logic               outEn,
  output logic               intReset,
  output logic               protoErr,
  output logic               overrun
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PIX - 1);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(RESET_WIN);

  logic               serInQ;
  logic               holdQ;
  logic               tokenAcc;
  logic               holdRise;
  logic [NUM_PIX-1:0] selQ;
  logic [IDX_W-1:0]   idxQ;
  logic [WIN_W-1:0]   winCnt;

  // Edge detection on the start and hold inputs.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serInQ <= 1'b0;
      holdQ  <= 1'b0;
    end else begin
      serInQ <= serIn;
      holdQ  <= holdIn;
    end
  end

  assign tokenAcc = serIn & ~serInQ;
  assign holdRise = holdIn & ~holdQ;

  // One-hot select chain: a new token clears every stage and seeds stage 0.
  generate
    for (genvar gi = 0; gi < NUM_PIX; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) selQ[gi] <= 1'b0;
          else       selQ[gi] <= tokenAcc;
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)         selQ[gi] <= 1'b0;
          else if (tokenAcc) selQ[gi] <= 1'b0;
          else               selQ[gi] <= selQ[gi-1];
        end
      end
    end
  endgenerate

  assign outEn  = |selQ;
  assign serOut = selQ[NUM_PIX-1];
  assign pixSel = selQ;

  // Binary position tracking the chain, used to address the capture bank.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           idxQ <= '0;
    else if (tokenAcc)   idxQ <= '0;
    else if (serOut)     idxQ <= '0;
    else if (outEn)      idxQ <= (idxQ == LAST_IDX) ? '0 : idxQ + 1'b1;
  end

  assign pixIndex = idxQ;

  // Integrator-reset window, reloaded by a token or a hold rise.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    winCnt <= '0;
    else if (tokenAcc | holdRise) winCnt <= WIN_LOAD;
    else if (winCnt != '0)        winCnt <= winCnt - 1'b1;
  end

  assign intReset = (winCnt != '0);

  // Misuse flags, one cycle each.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protoErr <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      protoErr <= serIn & serInQ;
      overrun  <= tokenAcc & outEn & ~serOut;
    end
  end

  assign strobe.capture = holdRise;
  assign strobe.valid   = outEn;

endmodule

// File: rtl/linescan_dpath.sv
`timescale 1ns/1ps
module linescan_dpath
  import linescan_pkg::*;
#(
  parameter int NUM_PIX = 384,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = $clog2(NUM_PIX)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strobe,
  input  logic [IDX_W-1:0]          pixIndex,
  input  logic [NUM_PIX*DATA_W-1:0] pixIn,
  output logic [DATA_W-1:0]         pixData,
  output logic                      pixValid
);

  logic [DATA_W-1:0] capBank [NUM_PIX];

  // Every pixel word is frozen on the same edge.
  generate
    for (genvar gp = 0; gp < NUM_PIX; gp++) begin : g_cap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               capBank[gp] <= '0;
        else if (strobe.capture) capBank[gp] <= pixIn[gp*DATA_W +: DATA_W];
      end
    end
  endgenerate

  assign pixValid = strobe.valid;
  assign pixData  = strobe.valid ? capBank[pixIndex] : '0;

endmodule

// File: rtl/linescan_seq.sv
`timescale 1ns/1ps
module linescan_seq
  import linescan_pkg::*;
#(
  parameter int NUM_PIX   = 384,
  parameter int DATA_W    = 8,
  parameter int RESET_WIN = 18,
  localparam int IDX_W    = $clog2(NUM_PIX),
  localparam int WIN_W    = $clog2(RESET_WIN + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      serIn,
  input  logic                      holdIn,
  input  logic [NUM_PIX*DATA_W-1:0] pixIn,
  output logic [NUM_PIX-1:0]        pixSel,
  output logic [DATA_W-1:0]         pixData,
  output logic                      pixValid,
  output logic [IDX_W-1:0]          pixIndex,
  output logic                      serOut,
  output logic                      outEn,
  output logic                      intReset,
  output logic                      protoErr,
  output logic                      overrun
);

  seqStrobe_t strobe;

  linescan_ctrl #(
    .NUM_PIX  (NUM_PIX),
    .RESET_WIN(RESET_WIN),
    .IDX_W    (IDX_W),
    .WIN_W    (WIN_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .serIn   (serIn),
    .holdIn  (holdIn),
    .strobe  (strobe),
    .pixIndex(pixIndex),
    .pixSel  (pixSel),
    .serOut  (serOut),
    .outEn   (outEn),
    .intReset(intReset),
    .protoErr(protoErr),
    .overrun (overrun)
  );

  linescan_dpath #(
    .NUM_PIX(NUM_PIX),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pixIndex(pixIndex),
    .pixIn   (pixIn),
    .pixData (pixData),
    .pixValid(pixValid)
  );

endmodule

// File: rtl/linescan_seq_chk.sv
`timescale 1ns/1ps
module linescan_seq_chk #(
  parameter int NUM_PIX = 384,
  parameter int IDX_W   = $clog2(NUM_PIX)
) (
  input logic               clk,
  input logic               rstN,
  input logic               serIn,
  input logic [NUM_PIX-1:0] pixSel,
  input logic               pixValid,
  input logic [IDX_W-1:0]   pixIndex,
  input logic               serOut,
  input logic               intReset,
  input logic               protoErr,
  input logic               overrun
);

  logic prevSerIn;
  logic accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSerIn <= 1'b0;
    else       prevSerIn <= serIn;
  end

  assign accept = serIn & ~prevSerIn;

  p_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (pixValid && pixIndex == '0 && pixSel[0]));

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pixSel));

  p_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !serOut && !accept) |=>
      (pixValid && pixIndex == IDX_W'($past(pixIndex) + 1'b1)));

  p_retire_r4: assert property (@(posedge clk) disable iff (!rstN)
    (serOut && !accept) |=> (!pixValid && !serOut));

  p_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> intReset);

  p_long_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (serIn && prevSerIn) |=> protoErr);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && pixValid && !serOut) |=> (overrun && pixIndex == '0));

endmodule

bind linescan_seq linescan_seq_chk #(
  .NUM_PIX(NUM_PIX),
  .IDX_W  (IDX_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .serIn   (serIn),
  .pixSel  (pixSel),
  .pixValid(pixValid),
  .pixIndex(pixIndex),
  .serOut  (serOut),
  .intReset(intReset),
  .protoErr(protoErr),
  .overrun (overrun)
);

// File: tb/linescan_seq_bench.sv
`timescale 1ns/1ps
module linescan_seq_bench;

  localparam int N   = 384;
  localparam int DW  = 8;
  localparam int WIN = 18;
  localparam int IW  = $clog2(N);

  logic clk = 1'b0;
  logic rstN;
  logic sIn, hIn;
  logic [N*DW-1:0] px1, px2;

  logic [N-1:0]  sel1, sel2;
  logic [DW-1:0] data1, data2;
  logic          valid1, valid2, so1, so2, oe1, oe2, ir1, ir2, pe1, pe2, ov1, ov2;
  logic [IW-1:0] idx1, idx2;

  int tests  = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  linescan_seq u_linescan_seq (
    .clk(clk), .rstN(rstN), .serIn(sIn), .holdIn(hIn), .pixIn(px1),
    .pixSel(sel1), .pixData(data1), .pixValid(valid1), .pixIndex(idx1),
    .serOut(so1), .outEn(oe1), .intReset(ir1), .protoErr(pe1), .overrun(ov1)
  );

  // Second section cascaded behind the first (R9).
  linescan_seq u_linescan_seq_b (
    .clk(clk), .rstN(rstN), .serIn(so1), .holdIn(hIn), .pixIn(px2),
    .pixSel(sel2), .pixData(data2), .pixValid(valid2), .pixIndex(idx2),
    .serOut(so2), .outEn(oe2), .intReset(ir2), .protoErr(pe2), .overrun(ov2)
  );

  // Cycle model of the requirements, one slot per section.
  bit            mAct [2];
  int            mIdx [2];
  int            mCnt [2];
  bit            mPs  [2];
  bit            mPh  [2];
  bit            mErr [2];
  bit            mOv  [2];
  logic [DW-1:0] mCap [2][N];

  task automatic modelReset();
    for (int k = 0; k < 2; k++) begin
      mAct[k] = 0; mIdx[k] = 0; mCnt[k] = 0; mPs[k] = 0; mPh[k] = 0;
      mErr[k] = 0; mOv[k] = 0;
      for (int i = 0; i < N; i++) mCap[k][i] = '0;
    end
  endtask

  task automatic modelStep(int k, bit s, bit h, logic [N*DW-1:0] px);
    bit acc, hr;
    acc = s && !mPs[k];
    hr  = h && !mPh[k];
    mErr[k] = s && mPs[k];
    mOv[k]  = acc && mAct[k] && (mIdx[k] != N - 1);
    if (hr) for (int i = 0; i < N; i++) mCap[k][i] = px[i*DW +: DW];
    if (acc) begin
      mAct[k] = 1; mIdx[k] = 0;
    end else if (mAct[k]) begin
      if (mIdx[k] == N - 1) begin mAct[k] = 0; mIdx[k] = 0; end
      else mIdx[k] = mIdx[k] + 1;
    end
    if (acc || hr)      mCnt[k] = WIN;
    else if (mCnt[k] > 0) mCnt[k] = mCnt[k] - 1;
    mPs[k] = s;
    mPh[k] = h;
  endtask

  task automatic chk(bit ok, string what, logic [N-1:0] act, logic [N-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cmpInst(int k, logic [N-1:0] sel, logic [DW-1:0] data, logic valid,
                         logic [IW-1:0] idx, logic so, logic oe, logic ir,
                         logic pe, logic ov);
    logic [N-1:0]  eSel;
    logic [DW-1:0] eData;
    int            eIdx;
    string         pre;
    pre   = (k == 0) ? "" : "R9 section2 ";
    eIdx  = mAct[k] ? mIdx[k] : 0;
    eSel  = mAct[k] ? (N'(1) << mIdx[k]) : '0;
    eData = mAct[k] ? mCap[k][mIdx[k]] : '0;
    chk(valid == mAct[k], {pre, "R1 pixValid"}, N'(valid), N'(mAct[k]));
    chk(oe == mAct[k], {pre, "R4 outEn"}, N'(oe), N'(mAct[k]));
    chk(int'(idx) == eIdx, {pre, "R2 pixIndex"}, N'(idx), N'(eIdx));
    chk(sel == eSel, {pre, "R2 pixSel"}, sel, eSel);
    chk(data == eData, {pre, "R3 R5 pixData"}, N'(data), N'(eData));
    chk(so == (mAct[k] && mIdx[k] == N - 1), {pre, "R4 serOut"}, N'(so),
        N'(mAct[k] && mIdx[k] == N - 1));
    chk(ir == (mCnt[k] != 0), {pre, "R6 intReset"}, N'(ir), N'(mCnt[k] != 0));
    chk(pe == mErr[k], {pre, "R7 protoErr"}, N'(pe), N'(mErr[k]));
    chk(ov == mOv[k], {pre, "R8 overrun"}, N'(ov), N'(mOv[k]));
  endtask

  // Advance one clock: model sees the pre-edge inputs, outputs are sampled 1 ns after.
  task automatic tick();
    modelStep(0, sIn, hIn, px1);
    modelStep(1, so1, hIn, px2);
    @(posedge clk);
    #1;
    cmpInst(0, sel1, data1, valid1, idx1, so1, oe1, ir1, pe1, ov1);
    cmpInst(1, sel2, data2, valid2, idx2, so2, oe2, ir2, pe2, ov2);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic randPix();
    for (int i = 0; i < N; i++) begin
      px1[i*DW +: DW] = DW'($urandom);
      px2[i*DW +: DW] = DW'($urandom);
    end
  endtask

  task automatic token(int len);
    sIn = 1'b1; hIn = 1'b1;
    ticks(len);
    sIn = 1'b0; hIn = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240517));
    sIn = 0; hIn = 0; px1 = '0; px2 = '0;
    rstN = 1'b0;
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    // R10: every output low in reset.
    chk({sel1, data1, valid1, idx1, so1, oe1, ir1, pe1, ov1} == '0, "R10 reset outputs",
        N'({valid1, so1, oe1, ir1, pe1, ov1}), '0);
    chk(sel1 == '0 && data1 == '0 && idx1 == '0, "R10 reset select/data", sel1, '0);
    rstN = 1'b1;

    // Full scan through both sections; pixIn changes mid scan must not show (R5).
    randPix();
    token(1);
    ticks(100);
    randPix();
    ticks(700);

    // Long start pulse (R7).
    randPix();
    token(2);
    ticks(800);

    // Early token mid readout (R8).
    token(1);
    ticks(50);
    token(1);
    ticks(800);

    // Back-to-back token on the retiring edge: no overrun (R8, R4).
    randPix();
    token(1);
    ticks(N - 1);
    token(1);
    ticks(800);

    // Hold alone: capture and window without a readout (R5, R6).
    randPix();
    hIn = 1'b1; tick(); hIn = 1'b0;
    ticks(30);
    hIn = 1'b1; tick(); hIn = 1'b0;
    ticks(5);
    hIn = 1'b1; tick(); hIn = 1'b0;
    ticks(30);

    // Constrained random traffic.
    for (int c = 0; c < 20000; c++) begin
      int r;
      r = int'($urandom % 1000);
      sIn = (r < 4);
      hIn = (r < 3) || (r > 996);
      if (r == 500) randPix();
      if (r == 0 && ($urandom % 2) == 0) tick();
      tick();
    end
    sIn = 0; hIn = 0;
    ticks(800);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule